// File: doc/BRIEF.md
# Pipelined Debug Halt Controller

This block decides when a small in-order core with fetch, decode and execute stages stops and enters debug state. Three things can cause a halt: a breakpoint mark on a fetched instruction, a watchpoint hit on a data access, and a level-sensitive external halt request. The breakpoint mark may come from an address comparator or from a pin sampled with the fetch. It is captured when the instruction enters the pipeline and moves with that instruction, one stage per advance. A pipeline flush, from a branch or an exception, discards every mark in flight. A mark only causes a halt if its instruction reaches execute.

A marked instruction in execute always causes a halt, and no condition code is consulted. The block raises an execute-suppress output for as long as that instruction sits in execute, and keeps it raised for the whole debug session. As a result, the core state seen in debug is the state from before that instruction. A watchpoint is never lost. It is held pending until the current instruction completes, which covers every transfer cycle of a multi-word load or store. When the block halts, it emits a one-cycle entry pulse, records a cause code and sets a debug-state flag. The flag clears when the debugger sends an exit pulse. Execution then restarts at the instruction that was marked; it is refetched without its mark because the breakpoint has been removed.

Top module: `debug_halt_ctrl`

## Requirements
- R1: After reset, `dbgActive`, `dbgEnter` and `execSuppress` are 0 and `dbgCause` is 2'b00.
- R2: An instruction fetched with `fetchValid`=1 and `bkptIn`=1 while `advance`=1 reaches execute after two advancing edges. From then on, `execSuppress` is 1. One edge later, `dbgEnter` and `dbgActive` are 1 and `dbgCause` is 2'b01.
- R3: An edge with `flush`=1 clears every breakpoint mark in the pipeline, so no halt follows. An instruction fetched again afterwards with `bkptIn`=1 is marked afresh and does halt.
- R4: `execSuppress` is 1 whenever a marked instruction is in execute, and throughout debug state.
- R5: A `watchHit` pulse is latched. It causes a halt, with cause 2'b10, only on an edge where `instrDone`=1 and `multiBusy`=0. While `multiBusy`=1, or while `instrDone`=0, no watchpoint halt occurs.
- R6: `dbgReq`=1 causes a halt with cause 2'b11 on an edge where `multiBusy`=0. It is ignored while `multiBusy`=1.
- R7: When several sources are ready on the same edge, the breakpoint in execute wins first, then the watchpoint, then the request. A watchpoint that loses stays pending and is taken later.
- R8: `dbgActive` stays 1 until an edge with `exitDbg`=1. No new halt is taken while it is 1. `exitDbg` has no effect outside debug state.
- R9: `dbgEnter` is high for exactly one cycle, in the same cycle that `dbgActive` rises. `dbgCause` holds its value until the next halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Pipeline moves one stage this edge |
| flush | input | 1 | Pipeline flush (branch or exception) |
| fetchValid | input | 1 | A fetched instruction enters decode on advance |
| bkptIn | input | 1 | Breakpoint mark for the fetched instruction |
| watchHit | input | 1 | Watchpoint hit on the current data access |
| instrDone | input | 1 | Instruction in execute completes this cycle |
| multiBusy | input | 1 | Multi-word transfer still has words to move |
| dbgReq | input | 1 | External halt request (level) |
| exitDbg | input | 1 | Leave debug state |
| execSuppress | output | 1 | Block register and memory side effects of execute |
| dbgEnter | output | 1 | One-cycle debug entry pulse |
| dbgCause | output | 2 | Cause code: 01 breakpoint, 10 watchpoint, 11 request |
| dbgActive | output | 1 | Core is in debug state |

## Verification
The case that needs care is when a breakpointed instruction reaches execute on the same edge that a watchpoint hit arrives and a halt request is high. The bench sets up this collision deliberately. It marks an instruction, then drives `watchHit`, `instrDone` and `dbgReq` exactly in the cycle that instruction sits in execute. It judges the result through a queue of expected cause codes. First, the breakpoint halt must be reported. After exit, the surviving watchpoint must be reported. After the next exit, the still-asserted request must be reported. Any reordering or missing entry shows up as a miscompare.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int CAUSE_W = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_BKPT  = 2'b01,
    CAUSE_WATCH = 2'b10,
    CAUSE_REQ   = 2'b11
  } cause_e;

  typedef struct packed {
    logic   enter;
    logic   takeWatch;
    cause_e cause;
  } strobe_t;
endpackage

// File: rtl/dbg_halt_path.sv
module dbg_halt_path
  import dbg_halt_pkg::*;
#(
  parameter int TAG_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               advance,
  input  logic               flush,
  input  logic               fetchValid,
  input  logic               bkptIn,
  input  logic               watchHit,
  input  logic               exitDbg,
  input  strobe_t            strobe,
  output logic               exeMarked,
  output logic               wpPend,
  output logic               dbgActive,
  output logic               dbgEnter,
  output logic [CAUSE_W-1:0] dbgCause,
  output logic               execSuppress
);
  localparam int LAST = TAG_STAGES - 1;

  logic [TAG_STAGES-1:0] stValid;
  logic [TAG_STAGES-1:0] stMark;
  logic                  clearAll;

  // Any flush, the halt itself, or the debug session empties the mark pipe.
  assign clearAll = flush | strobe.enter | dbgActive;

  for (genvar s = 0; s < TAG_STAGES; s++) begin : g_stage
    logic inValid, inMark, vld, mrk;
    if (s == 0) begin : g_head
      assign inValid = fetchValid;
      assign inMark  = fetchValid & bkptIn;
    end else begin : g_body
      assign inValid = stValid[s-1];
      assign inMark  = stMark[s-1];
    end
    always_ff @(posedge clk) begin
      if (!rstN || clearAll) begin
        vld <= 1'b0;
        mrk <= 1'b0;
      end else if (advance) begin
        vld <= inValid;
        mrk <= inMark;
      end
    end
    assign stValid[s] = vld;
    assign stMark[s]  = mrk;
  end

  assign exeMarked    = stValid[LAST] & stMark[LAST];
  assign execSuppress = exeMarked | dbgActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wpPend    <= 1'b0;
      dbgActive <= 1'b0;
      dbgEnter  <= 1'b0;
      dbgCause  <= CAUSE_NONE;
    end else begin
      wpPend   <= (wpPend | (watchHit & ~dbgActive)) & ~strobe.takeWatch;
      dbgEnter <= strobe.enter;
      if (strobe.enter) begin
        dbgActive <= 1'b1;
        dbgCause  <= strobe.cause;
      end else if (exitDbg) begin
        dbgActive <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_halt_arbiter.sv
module dbg_halt_arbiter
  import dbg_halt_pkg::*;
(
  input  logic    exeMarked,
  input  logic    wpPend,
  input  logic    watchHit,
  input  logic    instrDone,
  input  logic    multiBusy,
  input  logic    dbgReq,
  input  logic    dbgActive,
  output strobe_t strobe
);
  logic bkptReady, watchReady, reqReady;

  assign bkptReady  = exeMarked & ~dbgActive;
  assign watchReady = (wpPend | watchHit) & instrDone & ~multiBusy & ~dbgActive;
  assign reqReady   = dbgReq & ~multiBusy & ~dbgActive;

  always_comb begin
    strobe = '{enter: 1'b0, takeWatch: 1'b0, cause: CAUSE_NONE};
    if (bkptReady) begin
      strobe.enter = 1'b1;
      strobe.cause = CAUSE_BKPT;
    end else if (watchReady) begin
      strobe.enter     = 1'b1;
      strobe.takeWatch = 1'b1;
      strobe.cause     = CAUSE_WATCH;
    end else if (reqReady) begin
      strobe.enter = 1'b1;
      strobe.cause = CAUSE_REQ;
    end
  end
endmodule

// File: rtl/debug_halt_ctrl.sv
module debug_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int TAG_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               advance,
  input  logic               flush,
  input  logic               fetchValid,
  input  logic               bkptIn,
  input  logic               watchHit,
  input  logic               instrDone,
  input  logic               multiBusy,
  input  logic               dbgReq,
  input  logic               exitDbg,
  output logic               execSuppress,
  output logic               dbgEnter,
  output logic [CAUSE_W-1:0] dbgCause,
  output logic               dbgActive
);
  strobe_t strobe;
  logic    exeMarked, wpPend;

  dbg_halt_path #(.TAG_STAGES(TAG_STAGES)) u_path (
    .clk(clk), .rstN(rstN), .advance(advance), .flush(flush),
    .fetchValid(fetchValid), .bkptIn(bkptIn), .watchHit(watchHit),
    .exitDbg(exitDbg), .strobe(strobe), .exeMarked(exeMarked),
    .wpPend(wpPend), .dbgActive(dbgActive), .dbgEnter(dbgEnter),
    .dbgCause(dbgCause), .execSuppress(execSuppress)
  );

  dbg_halt_arbiter u_arb (
    .exeMarked(exeMarked), .wpPend(wpPend), .watchHit(watchHit),
    .instrDone(instrDone), .multiBusy(multiBusy), .dbgReq(dbgReq),
    .dbgActive(dbgActive), .strobe(strobe)
  );
endmodule

// File: rtl/debug_halt_checker.sv
module debug_halt_checker (
  input logic       clk,
  input logic       rstN,
  input logic       multiBusy,
  input logic       dbgReq,
  input logic       exitDbg,
  input logic       execSuppress,
  input logic       dbgEnter,
  input logic [1:0] dbgCause,
  input logic       dbgActive
);
  assert_enter_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    dbgEnter |=> !dbgEnter);
  assert_enter_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    dbgEnter |-> $rose(dbgActive));
  assert_hold_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dbgActive && !exitDbg) |=> dbgActive);
  assert_suppress_in_debug_R4: assert property (@(posedge clk) disable iff (!rstN)
    dbgActive |-> execSuppress);
  assert_watch_waits_R5: assert property (@(posedge clk) disable iff (!rstN)
    multiBusy |=> !(dbgEnter && dbgCause == 2'b10));
  assert_req_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dbgEnter && dbgCause == 2'b11) |-> ($past(dbgReq) && !$past(multiBusy)));
  assert_cause_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    dbgActive |-> dbgCause != 2'b00);
endmodule

bind debug_halt_ctrl debug_halt_checker u_chk (
  .clk(clk), .rstN(rstN), .multiBusy(multiBusy), .dbgReq(dbgReq),
  .exitDbg(exitDbg), .execSuppress(execSuppress), .dbgEnter(dbgEnter),
  .dbgCause(dbgCause), .dbgActive(dbgActive)
);

// File: tb/debug_halt_ctrl_bench.sv
`timescale 1ns/1ps
module debug_halt_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic advance = 0, flush = 0, fetchValid = 0, bkptIn = 0, watchHit = 0;
  logic instrDone = 0, multiBusy = 0, dbgReq = 0, exitDbg = 0;
  logic execSuppress, dbgEnter, dbgActive;
  logic [1:0] dbgCause;

  int vectors = 0;
  int miscompares = 0;
  logic [1:0] expQ[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  debug_halt_ctrl u_debug_halt_ctrl (
    .clk(clk), .rstN(rstN), .advance(advance), .flush(flush),
    .fetchValid(fetchValid), .bkptIn(bkptIn), .watchHit(watchHit),
    .instrDone(instrDone), .multiBusy(multiBusy), .dbgReq(dbgReq),
    .exitDbg(exitDbg), .execSuppress(execSuppress), .dbgEnter(dbgEnter),
    .dbgCause(dbgCause), .dbgActive(dbgActive)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expectEntry(logic [1:0] cause);
    expQ.push_back(cause);
  endtask

  // Monitor: every entry pulse is matched against the scoreboard queue (R9, R7).
  always @(negedge clk) begin
    if (rstN && dbgEnter) begin
      vectors++;
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL R9 unexpected entry actual=%0h expected=none", dbgCause);
      end else begin
        logic [1:0] e;
        e = expQ.pop_front();
        if (dbgCause !== e) begin
          miscompares++;
          $display("FAIL R7 cause actual=%0h expected=%0h", dbgCause, e);
        end
      end
    end
  end

  task automatic leaveDebug();
    exitDbg = 1; tick(); exitDbg = 0;
    check("R8 exit clears", {7'b0, dbgActive}, 8'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R1 active", {7'b0, dbgActive}, 8'd0);
    check("R1 enter", {7'b0, dbgEnter}, 8'd0);
    check("R1 cause", {6'b0, dbgCause}, 8'd0);
    check("R1 suppress", {7'b0, execSuppress}, 8'd0);
    rstN = 1; tick();

    // R8: exit outside debug has no effect
    exitDbg = 1; tick(); exitDbg = 0; tick();
    check("R8 exit ignored", {7'b0, dbgActive}, 8'd0);

    // R2/R4: marked instruction travels to execute
    advance = 1; fetchValid = 1; bkptIn = 1; tick();
    bkptIn = 0;
    check("R2 not yet in execute", {7'b0, execSuppress}, 8'd0);
    expectEntry(2'b01);
    tick();
    check("R4 suppress in execute", {7'b0, execSuppress}, 8'd1);
    check("R2 not halted yet", {7'b0, dbgActive}, 8'd0);
    tick();
    check("R2 active", {7'b0, dbgActive}, 8'd1);
    check("R2 cause", {6'b0, dbgCause}, 8'd1);
    tick(); tick();
    check("R9 pulse ended", {7'b0, dbgEnter}, 8'd0);
    check("R4 suppress held", {7'b0, execSuppress}, 8'd1);
    // R8: request ignored during debug
    dbgReq = 1; tick(); tick(); dbgReq = 0;
    check("R8 still active", {7'b0, dbgActive}, 8'd1);
    leaveDebug();
    tick();

    // R3: flush discards mark
    bkptIn = 1; tick(); bkptIn = 0; flush = 1; tick(); flush = 0;
    tick(); tick(); tick();
    check("R3 no halt after flush", {7'b0, dbgActive}, 8'd0);
    check("R3 no suppress", {7'b0, execSuppress}, 8'd0);
    // R3: refetched and re-marked
    bkptIn = 1; expectEntry(2'b01); tick(); bkptIn = 0; tick(); tick();
    check("R3 re-mark halts", {7'b0, dbgActive}, 8'd1);
    leaveDebug();
    tick();

    // R5: watchpoint during a multi-word transfer
    multiBusy = 1; watchHit = 1; tick(); watchHit = 0;
    instrDone = 1; tick(); tick(); instrDone = 0; tick();
    check("R5 wait while busy", {7'b0, dbgActive}, 8'd0);
    multiBusy = 0; tick(); tick();
    check("R5 wait for done", {7'b0, dbgActive}, 8'd0);
    instrDone = 1; expectEntry(2'b10); tick(); instrDone = 0; tick();
    check("R5 watch halt", {6'b0, dbgCause}, 8'd2);
    leaveDebug();
    tick();

    // R6: request blocked by busy transfer
    multiBusy = 1; dbgReq = 1; tick(); tick();
    check("R6 blocked by busy", {7'b0, dbgActive}, 8'd0);
    multiBusy = 0; expectEntry(2'b11); tick(); dbgReq = 0; tick();
    check("R6 request halt", {6'b0, dbgCause}, 8'd3);
    leaveDebug();
    tick();

    // R7: all three sources on one edge
    bkptIn = 1; tick(); bkptIn = 0; tick();
    watchHit = 1; instrDone = 1; dbgReq = 1;
    expectEntry(2'b01); expectEntry(2'b10); expectEntry(2'b11);
    tick(); watchHit = 0; instrDone = 0; tick();
    check("R7 breakpoint first", {6'b0, dbgCause}, 8'd1);
    leaveDebug();
    instrDone = 1; tick(); instrDone = 0; tick();
    check("R7 watch second", {6'b0, dbgCause}, 8'd2);
    leaveDebug();
    tick(); dbgReq = 0; tick();
    check("R7 request third", {6'b0, dbgCause}, 8'd3);
    leaveDebug();
    tick(); tick();

    check("R9 all entries seen", expQ.size() == 0 ? 8'd0 : 8'd1, 8'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule